// File: doc/BRIEF.md
# Hardware Volume Button Controller

This block turns two active-low push buttons into steps of a master attenuation offset and a mute flag. Each button input is synchronised and then timed in millisecond ticks. A press counts only after it has been held for a minimum time. A held button repeats its step at a fixed period. Pressing both buttons together toggles mute. The 5-bit offset is added to the attenuation value that software programs, and the block drives the sum, clamped to the largest code, toward the DAC.

Software reads the offset and the mute flag on plain outputs and clears mute with a one-cycle pulse. The up, down and mute events appear as one-cycle status pulses.

The press logic is one state machine with these states:
- `ST_IDLE`: both buttons are released. Any low input moves to `ST_QUAL` and clears the tick counter.
- `ST_QUAL`: counts `PRESS_MS` ticks while a button is held. If both inputs return high first, it goes back to `ST_IDLE`. When the count completes, it goes to `ST_WAIT_REL` for a chord, `ST_HOLD_UP` for volume up alone, or `ST_HOLD_DN` for volume down alone. Each of these exits emits its event.
- `ST_HOLD_UP` / `ST_HOLD_DN`: emit a further step every `REPEAT_MS` ticks. Releasing the held button, or pressing the other one, moves to `ST_WAIT_REL`.
- `ST_WAIT_REL`: returns to `ST_IDLE` only once both inputs are high.

Top module: `hwvol_ctrl`

## Requirements
- R1: After reset, the offset is 0, mute is 0, and no event output is high.
- R2: A press that is released before `PRESS_MS` ticks have elapsed changes neither the offset nor mute, and raises no event.
- R3: A qualified single press of the up button lowers the offset by one and pulses `evt_up_o` once. A qualified single press of the down button raises the offset by one and pulses `evt_dn_o` once.
- R4: While a single button stays held after qualifying, a further step of the same direction occurs every `REPEAT_MS` ticks. A hold of `PRESS_MS + k*REPEAT_MS + REPEAT_MS/2` ticks therefore gives k+1 steps.
- R5: When both buttons are low at the moment qualification completes, mute toggles, `evt_mute_o` pulses once, and the offset is unchanged. A held chord never repeats.
- R6: A qualified single-button step clears mute, in addition to stepping the offset.
- R7: A one-cycle pulse on `mute_clr_i` clears mute. It has priority over a chord in the same cycle.
- R8: `att_o` equals `att_i + offset`, clamped to 2^ATT_W-1 (63 for the default width of 6).
- R9: After any qualified press, no new press can qualify until both inputs have been seen high. Pressing the second button while the first is held also stops the repeats.
- R10: The offset saturates at 0 and at 2^OFS_W-1 (31), with no wraparound. Steps at a limit still pulse their event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_n | input | 1 | Volume-up button, low when pressed, asynchronous |
| btn_dn_n | input | 1 | Volume-down button, low when pressed, asynchronous |
| att_i | input | ATT_W | Software master attenuation |
| mute_clr_i | input | 1 | Pulse that clears mute |
| ofs_o | output | OFS_W | Current attenuation offset |
| mute_o | output | 1 | Mute flag |
| att_o | output | ATT_W | Clamped sum of att_i and the offset |
| evt_up_o | output | 1 | One-cycle pulse per up step |
| evt_dn_o | output | 1 | One-cycle pulse per down step |
| evt_mute_o | output | 1 | One-cycle pulse per chord |

## Verification
The bench chooses hold times halfway between thresholds, so that the step count does not depend on the phase of the tick.

- It counts repeat steps over long holds. A design that counts from the start of the press, or that repeats a chord, returns the wrong number of events.
- It drives the offset into both limits. A design that wraps shows 0 after 31, or 31 after 0.
- It presses the second button during a hold and then releases the first. A design that skips the wait for both buttons to be released qualifies a spurious down press.
- It sweeps every attenuation value at the offsets 0, 4 and 31. A missing clamp makes the sum wrap to small codes.

// File: rtl/hwvol_pkg.sv
package hwvol_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_HOLD_UP,
        ST_HOLD_DN,
        ST_WAIT_REL
    } hv_state_t;
endpackage

// File: rtl/hwvol_sync.sv
module hwvol_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Reset to all ones: a released active-low button reads high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/hwvol_tick.sv
module hwvol_tick #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;
    logic          tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= (div_q == LAST);
            div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign tick_o = tick_q;

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/hwvol_fsm.sv
module hwvol_fsm
    import hwvol_pkg::*;
#(
    parameter int PRESS_MS  = 50,
    parameter int REPEAT_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic up_act_i,
    input  logic dn_act_i,
    output logic step_up_o,
    output logic step_dn_o,
    output logic chord_o
);
    localparam int LIM   = (PRESS_MS > REPEAT_MS) ? PRESS_MS : REPEAT_MS;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(PRESS_MS - 1);
    localparam logic [CNT_W-1:0] REP_LAST  = CNT_W'(REPEAT_MS - 1);

    hv_state_t        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx  = state_q;
        cnt_nx    = cnt_q;
        step_up_o = 1'b0;
        step_dn_o = 1'b0;
        chord_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_nx = '0;
                if (up_act_i || dn_act_i) state_nx = ST_QUAL;
            end
            ST_QUAL: begin
                if (!up_act_i && !dn_act_i) begin
                    state_nx = ST_IDLE;
                end else if (tick_i) begin
                    if (cnt_q == QUAL_LAST) begin
                        cnt_nx = '0;
                        if (up_act_i && dn_act_i) begin
                            chord_o  = 1'b1;
                            state_nx = ST_WAIT_REL;
                        end else if (up_act_i) begin
                            step_up_o = 1'b1;
                            state_nx  = ST_HOLD_UP;
                        end else begin
                            step_dn_o = 1'b1;
                            state_nx  = ST_HOLD_DN;
                        end
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD_UP: begin
                if (!up_act_i || dn_act_i) begin
                    state_nx = ST_WAIT_REL;
                end else if (tick_i) begin
                    if (cnt_q == REP_LAST) begin
                        cnt_nx    = '0;
                        step_up_o = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD_DN: begin
                if (!dn_act_i || up_act_i) begin
                    state_nx = ST_WAIT_REL;
                end else if (tick_i) begin
                    if (cnt_q == REP_LAST) begin
                        cnt_nx    = '0;
                        step_dn_o = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_WAIT_REL: begin
                if (!up_act_i && !dn_act_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assert_step_up_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_up_o |-> up_act_i && !dn_act_i);
    assert_step_dn_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn_o |-> dn_act_i && !up_act_i);
    assert_chord_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chord_o |-> up_act_i && dn_act_i);
    assert_chord_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chord_o |=> state_q == ST_WAIT_REL);
    assert_wait_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REL && (up_act_i || dn_act_i)) |=> state_q == ST_WAIT_REL);
endmodule

// File: rtl/hwvol_ctrl.sv
module hwvol_ctrl #(
    parameter int TICK_DIV  = 50000,
    parameter int PRESS_MS  = 50,
    parameter int REPEAT_MS = 200,
    parameter int OFS_W     = 5,
    parameter int ATT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_up_n,
    input  logic             btn_dn_n,
    input  logic [ATT_W-1:0] att_i,
    input  logic             mute_clr_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             mute_o,
    output logic [ATT_W-1:0] att_o,
    output logic             evt_up_o,
    output logic             evt_dn_o,
    output logic             evt_mute_o
);
    localparam int SUM_W = ATT_W + 1;
    localparam logic [OFS_W-1:0] OFS_MAX = {OFS_W{1'b1}};

    logic [1:0]       btn_s;
    logic             tick;
    logic             step_up, step_dn, chord;
    logic [OFS_W-1:0] ofs_q;
    logic             mute_q;
    logic [SUM_W-1:0] sum;

    hwvol_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({btn_up_n, btn_dn_n}),
        .q_o  (btn_s)
    );

    hwvol_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    hwvol_fsm #(.PRESS_MS(PRESS_MS), .REPEAT_MS(REPEAT_MS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .up_act_i (~btn_s[1]),
        .dn_act_i (~btn_s[0]),
        .step_up_o(step_up),
        .step_dn_o(step_dn),
        .chord_o  (chord)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (step_up && ofs_q != '0) begin
            ofs_q <= ofs_q - 1'b1;
        end else if (step_dn && ofs_q != OFS_MAX) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mute_q <= 1'b0;
        else if (mute_clr_i)       mute_q <= 1'b0;
        else if (chord)            mute_q <= ~mute_q;
        else if (step_up | step_dn) mute_q <= 1'b0;
    end

    always_comb begin
        sum   = {1'b0, att_i} + SUM_W'(ofs_q);
        att_o = sum[ATT_W] ? {ATT_W{1'b1}} : sum[ATT_W-1:0];
    end

    assign ofs_o      = ofs_q;
    assign mute_o     = mute_q;
    assign evt_up_o   = step_up;
    assign evt_dn_o   = step_dn;
    assign evt_mute_o = chord;

    always_comb begin
        assert_att_floor_R8: assert (att_o >= att_i);
    end
    assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_up_o, evt_dn_o, evt_mute_o}));
    assert_up_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up_o && ofs_o != '0) |=> ofs_o == $past(ofs_o) - 1'b1);
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_dn_o && ofs_o == OFS_MAX) |=> ofs_o == OFS_MAX);
    assert_chord_keeps_ofs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_mute_o |=> $stable(ofs_o));
    assert_step_unmutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_up_o || evt_dn_o) |=> !mute_o);
    assert_clr_unmutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mute_clr_i |=> !mute_o);
endmodule

// File: tb/hwvol_ctrl_test.sv
module hwvol_ctrl_test;
    localparam int DIV = 4;
    localparam int PMS = 3;
    localparam int RMS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic [5:0] att_in = '0;
    logic       mclr = 1'b0;
    logic [4:0] ofs;
    logic       mute;
    logic [5:0] att_out;
    logic       eu, ed, em;

    int n_run = 0;
    int n_fail = 0;
    int c_up = 0, c_dn = 0, c_mu = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hwvol_ctrl #(.TICK_DIV(DIV), .PRESS_MS(PMS), .REPEAT_MS(RMS),
                 .OFS_W(5), .ATT_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .btn_up_n(up_n), .btn_dn_n(dn_n),
        .att_i(att_in), .mute_clr_i(mclr), .ofs_o(ofs), .mute_o(mute),
        .att_o(att_out), .evt_up_o(eu), .evt_dn_o(ed), .evt_mute_o(em)
    );

    always @(negedge clk) begin
        if (eu) c_up++;
        if (ed) c_dn++;
        if (em) c_mu++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold for the given number of ms ticks, then release and settle.
    task automatic press(input bit u, input bit d, input int ticks);
        @(negedge clk);
        up_n = ~u;
        dn_n = ~d;
        wait_clk(ticks * DIV);
        up_n = 1'b1;
        dn_n = 1'b1;
        wait_clk(10);
    endtask

    function automatic int hold_ticks(input int k);
        return PMS + k * RMS + RMS / 2;
    endfunction

    task automatic sweep(input string req, input int o);
        for (int m = 0; m < 64; m++) begin
            att_in = 6'(m);
            #1;
            chk(req, int'(att_out), (m + o > 63) ? 63 : m + o);
        end
    endtask

    initial begin
        int u0, d0, m0, base;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 ofs", int'(ofs), 0);
        chk("R1 mute", int'(mute), 0);
        chk("R1 events", int'({eu, ed, em}), 0);
        sweep("R8 ofs0", 0);

        // R2 short presses
        u0 = c_up; d0 = c_dn;
        press(1, 0, 1);
        press(0, 1, 1);
        chk("R2 ofs", int'(ofs), 0);
        chk("R2 events", (c_up - u0) + (c_dn - d0), 0);

        // R3 single down step
        d0 = c_dn;
        press(0, 1, hold_ticks(0));
        chk("R3 dn ofs", int'(ofs), 1);
        chk("R3 dn evt", c_dn - d0, 1);

        // R4 auto-repeat: k=3 -> 4 steps
        d0 = c_dn;
        press(0, 1, hold_ticks(3));
        chk("R4 repeat ofs", int'(ofs), 5);
        chk("R4 repeat evt", c_dn - d0, 4);

        // R3 single up step
        u0 = c_up;
        press(1, 0, hold_ticks(0));
        chk("R3 up ofs", int'(ofs), 4);
        chk("R3 up evt", c_up - u0, 1);
        sweep("R8 ofs4", 4);

        // R5 chord toggles, no repeat
        m0 = c_mu;
        press(1, 1, hold_ticks(0));
        chk("R5 mute set", int'(mute), 1);
        chk("R5 ofs kept", int'(ofs), 4);
        press(1, 1, hold_ticks(3));
        chk("R5 mute toggled off", int'(mute), 0);
        chk("R5 single evt per chord", c_mu - m0, 2);
        chk("R5 ofs kept long", int'(ofs), 4);

        // R6 single step unmutes
        press(1, 1, hold_ticks(0));
        press(0, 1, hold_ticks(0));
        chk("R6 dn unmute", int'(mute), 0);
        chk("R6 dn ofs", int'(ofs), 5);
        press(1, 1, hold_ticks(0));
        chk("R6 muted again", int'(mute), 1);
        press(1, 0, hold_ticks(0));
        chk("R6 up unmute", int'(mute), 0);
        chk("R6 up ofs", int'(ofs), 4);

        // R7 software clear
        press(1, 1, hold_ticks(0));
        chk("R7 muted", int'(mute), 1);
        @(negedge clk); mclr = 1'b1;
        @(negedge clk); mclr = 1'b0;
        chk("R7 cleared", int'(mute), 0);
        chk("R7 ofs kept", int'(ofs), 4);

        // R9 release both before a new press
        u0 = c_up; d0 = c_dn;
        @(negedge clk); up_n = 1'b0;
        wait_clk(20);
        dn_n = 1'b0;
        wait_clk(10);
        up_n = 1'b1;
        wait_clk(60);
        dn_n = 1'b1;
        wait_clk(10);
        chk("R9 ofs", int'(ofs), 3);
        chk("R9 up evt", c_up - u0, 1);
        chk("R9 no dn evt", c_dn - d0, 0);

        // R10 saturation high
        d0 = c_dn; base = 3;
        press(0, 1, hold_ticks(35));
        chk("R10 sat high", int'(ofs), 31);
        chk("R10 evt at limit", c_dn - d0, 36);
        sweep("R8 ofs31", 31);

        // R10 saturation low
        press(1, 0, hold_ticks(40));
        chk("R10 sat low", int'(ofs), 0);
        if (base != 3) chk("R10 base", base, 3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule